// File: doc/BRIEF.md
# Byte-Wide Link Transmitter

This block sends 32-bit words off-chip over an 8-bit data bus. The block drives the link clock itself, and the far end paces the traffic through an acknowledge input. Software or a DMA engine writes words into a small internal FIFO. The transmitter moves each word into a shift register and drives it onto the pins one byte per link clock period, least significant byte first. A new byte appears in the same core cycle in which the link clock rises, so the receiver can capture it on the falling edge.

The link clock comes from the core clock through a ratio divider. The divider supports divide-by-2, 3 and 4, and a fractional divide-by-2.5 that alternates periods of 2 and 3 core cycles. A transfer starts only at a word boundary, and only while acknowledge is high. When acknowledge is low the link clock parks low once the current word has finished. When the next word is already buffered, it follows the previous one with no idle period. A write to a full FIFO is refused and sets a sticky error flag. Software clears that flag by writing a one to it.

The controller has two states. `ST_IDLE` keeps the divider stopped. It moves to `ST_SEND` when a word is buffered and acknowledge is high. `ST_SEND` runs the divider, and on every link clock rising edge it either loads the next word (at a word boundary) or shifts out the next byte. At a word boundary with no buffered word, or with acknowledge low, it returns to `ST_IDLE`. In that case it suppresses the rising edge, so no clock pulse is produced without data.

Top module: `lnk_tx_top`

## Requirements
- R1: After reset, `lnk_clk`, `lnk_data`, `sts_ibuf_cnt`, `sts_tx_active` and `sts_ovf` are all zero.
- R2: `cfg_ratio` selects the link clock period within a burst: 0 gives 2 core cycles, 1 gives periods alternating 2, 3, 2, 3 (starting with 2 at each burst), 2 gives 3 cycles and 3 gives 4 cycles, measured between consecutive rising edges of `lnk_clk`.
- R3: `lnk_clk` stays high for 1 core cycle per period for ratios 0, 1 and 2, and for 2 core cycles for ratio 3.
- R4: Each word is sent as four bytes, bits [7:0] first and bits [31:24] last. `lnk_data` changes only in the cycle in which `lnk_clk` rises.
- R5: When the next word is buffered and `lnk_ack` is high at a word boundary, the first byte of the next word follows the last byte of the current word after exactly one link period, with no gap.
- R6: `lnk_ack` is examined only at word boundaries. If it is low there, the current word completes, no further rising edge occurs, and `lnk_clk` stays low until `lnk_ack` returns high. Sending then resumes with the buffered word.
- R7: The internal FIFO holds `IBUF_DEPTH` words in write order. `sts_ibuf_cnt` shows its occupancy and `sts_ibuf_full` is high when it holds `IBUF_DEPTH` words.
- R8: A write (`wr_en` high) while `sts_ibuf_full` is high is refused: the word is never transmitted, the occupancy does not grow, and `sts_ovf` is set in the next cycle.
- R9: `sts_ovf` is sticky and clears when `err_clr` is high. If a refused write and `err_clr` arrive in the same cycle, the flag stays set.
- R10: When the block is idle, `lnk_ack` is high and a word is written, `sts_tx_active` is high one cycle after the write edge and `lnk_clk` rises two cycles after it, with byte 0 on `lnk_data`. Whenever `sts_tx_active` is low, `lnk_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ratio | input | 2 | Link clock ratio select (0: /2, 1: /2.5, 2: /3, 3: /4); change only while idle |
| wr_en | input | 1 | Write strobe for the internal FIFO |
| wr_data | input | WORD_W | Word to transmit |
| err_clr | input | 1 | Write-one-to-clear for the overflow flag |
| lnk_ack | input | 1 | Acknowledge from the receiving end; high allows a new word to start |
| lnk_clk | output | 1 | Link clock to the receiver |
| lnk_data | output | LINK_W | Link data byte |
| sts_ibuf_cnt | output | $clog2(IBUF_DEPTH+1) | Number of words in the internal FIFO |
| sts_ibuf_full | output | 1 | Internal FIFO full |
| sts_tx_active | output | 1 | Transmitter running (divider active) |
| sts_ovf | output | 1 | Sticky overflow error |

## Verification
The checker looks at every cycle for the following:
- the link clock staying low while the block is inactive;
- the data lines moving only on a rising link clock edge;
- the high time of the link clock for each ratio;
- the FIFO occupancy bound;
- the refusal of writes to a full FIFO;
- the stickiness of the overflow flag.

Some behaviours only the bench scenarios can show:
- the exact period sequence per ratio, including the 2/3 alternation of the fractional setting;
- the seamless join between back-to-back words;
- the byte order;
- parking the clock until acknowledge returns;
- the proof that a refused word never reaches the pins.

The bench shows these by sweeping every ratio across several burst lengths.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;

    typedef enum logic [1:0] {
        RATIO_2   = 2'd0,
        RATIO_2P5 = 2'd1,
        RATIO_3   = 2'd2,
        RATIO_4   = 2'd3
    } lnk_ratio_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/lnk_tx_ibuf.sv
module lnk_tx_ibuf #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 2,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              err_clr,
    output logic [WORD_W-1:0] rd_data,
    output logic              vld,
    output logic [CW-1:0]     cnt,
    output logic              full,
    output logic              ovf
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;
    logic              accept;
    logic              take;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign vld     = (cnt != '0);
    assign accept  = wr_en && !full;
    assign take    = rd_en && vld;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (accept) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (take) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            unique case ({accept, take})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (wr_en && full) begin
                ovf <= 1'b1;
            end else if (err_clr) begin
                ovf <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lnk_tx_clkdiv.sv
module lnk_tx_clkdiv
    import lnk_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lnk_ratio_e ratio,
    input  logic       en,
    input  logic       hold,
    output logic       edge_o,
    output logic       lnk_clk_o
);

    logic [2:0] cnt_q;
    logic       alt_q;
    logic [2:0] period;
    logic [2:0] hi_len;

    always_comb begin
        unique case (ratio)
            RATIO_2:   period = 3'd2;
            RATIO_2P5: period = alt_q ? 3'd3 : 3'd2;
            RATIO_3:   period = 3'd3;
            RATIO_4:   period = 3'd4;
            default:   period = 3'd2;
        endcase
        hi_len = (ratio == RATIO_4) ? 3'd2 : 3'd1;
    end

    assign edge_o = en && (cnt_q == 3'd0);

    always_ff @(posedge clk) begin
        if (!rst_n || !en || hold) begin
            cnt_q     <= 3'd0;
            alt_q     <= 1'b0;
            lnk_clk_o <= 1'b0;
        end else begin
            lnk_clk_o <= (cnt_q < hi_len);
            if (cnt_q == period - 3'd1) begin
                cnt_q <= 3'd0;
                alt_q <= ~alt_q;
            end else begin
                cnt_q <= cnt_q + 3'd1;
            end
        end
    end

endmodule

// File: rtl/lnk_tx_fsm.sv
module lnk_tx_fsm
    import lnk_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LINK_W = 8,
    localparam int BYTES = WORD_W / LINK_W,
    localparam int BW    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ibuf_vld,
    input  logic [WORD_W-1:0] ibuf_data,
    input  logic              ack,
    input  logic              edge_i,
    output logic              pop,
    output logic              div_en,
    output logic              div_hold,
    output logic [LINK_W-1:0] lnk_data,
    output logic              active
);

    tx_state_e         state_q;
    tx_state_e         state_nxt;
    logic [BW-1:0]     bidx_q;
    logic [WORD_W-1:0] shreg_q;
    logic              load;
    logic              shift;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // next state and control outputs
    always_comb begin
        state_nxt = state_q;
        pop       = 1'b0;
        div_hold  = 1'b0;
        load      = 1'b0;
        shift     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ibuf_vld && ack) begin
                    state_nxt = ST_SEND;
                end
            end
            ST_SEND: begin
                if (edge_i) begin
                    if (bidx_q == '0) begin
                        if (ibuf_vld && ack) begin
                            pop  = 1'b1;
                            load = 1'b1;
                        end else begin
                            div_hold  = 1'b1;
                            state_nxt = ST_IDLE;
                        end
                    end else begin
                        shift = 1'b1;
                    end
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
        div_en = (state_q == ST_SEND);
        active = div_en;
    end

    // byte serialiser
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bidx_q   <= '0;
            shreg_q  <= '0;
            lnk_data <= '0;
        end else if (load) begin
            lnk_data <= ibuf_data[LINK_W-1:0];
            shreg_q  <= ibuf_data >> LINK_W;
            bidx_q   <= BW'(1);
        end else if (shift) begin
            lnk_data <= shreg_q[LINK_W-1:0];
            shreg_q  <= shreg_q >> LINK_W;
            bidx_q   <= (bidx_q == BW'(BYTES - 1)) ? '0 : bidx_q + 1'b1;
        end
    end

endmodule

// File: rtl/lnk_tx_top.sv
module lnk_tx_top
    import lnk_tx_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int LINK_W     = 8,
    parameter int IBUF_DEPTH = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        cfg_ratio,
    input  logic                              wr_en,
    input  logic [WORD_W-1:0]                 wr_data,
    input  logic                              err_clr,
    input  logic                              lnk_ack,
    output logic                              lnk_clk,
    output logic [LINK_W-1:0]                 lnk_data,
    output logic [$clog2(IBUF_DEPTH+1)-1:0]   sts_ibuf_cnt,
    output logic                              sts_ibuf_full,
    output logic                              sts_tx_active,
    output logic                              sts_ovf
);

    logic [WORD_W-1:0] ibuf_data;
    logic              ibuf_vld;
    logic              pop;
    logic              div_en;
    logic              div_hold;
    logic              div_edge;
    lnk_ratio_e        ratio;

    assign ratio = lnk_ratio_e'(cfg_ratio);

    lnk_tx_ibuf #(
        .WORD_W (WORD_W),
        .DEPTH  (IBUF_DEPTH)
    ) i_ibuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (pop),
        .err_clr (err_clr),
        .rd_data (ibuf_data),
        .vld     (ibuf_vld),
        .cnt     (sts_ibuf_cnt),
        .full    (sts_ibuf_full),
        .ovf     (sts_ovf)
    );

    lnk_tx_clkdiv i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio     (ratio),
        .en        (div_en),
        .hold      (div_hold),
        .edge_o    (div_edge),
        .lnk_clk_o (lnk_clk)
    );

    lnk_tx_fsm #(
        .WORD_W (WORD_W),
        .LINK_W (LINK_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ibuf_vld  (ibuf_vld),
        .ibuf_data (ibuf_data),
        .ack       (lnk_ack),
        .edge_i    (div_edge),
        .pop       (pop),
        .div_en    (div_en),
        .div_hold  (div_hold),
        .lnk_data  (lnk_data),
        .active    (sts_tx_active)
    );

endmodule

// File: rtl/lnk_tx_chk.sv
module lnk_tx_chk #(
    parameter int LINK_W     = 8,
    parameter int IBUF_DEPTH = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [1:0]                      cfg_ratio,
    input logic                            wr_en,
    input logic                            err_clr,
    input logic                            lnk_clk,
    input logic [LINK_W-1:0]               lnk_data,
    input logic [$clog2(IBUF_DEPTH+1)-1:0] sts_ibuf_cnt,
    input logic                            sts_ibuf_full,
    input logic                            sts_tx_active,
    input logic                            sts_ovf
);

    assert_clk_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_tx_active |-> !lnk_clk);

    assert_data_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(lnk_clk) |-> $stable(lnk_data));

    assert_short_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lnk_clk) && cfg_ratio != 2'd3) |=> !lnk_clk);

    assert_long_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lnk_clk) && cfg_ratio == 2'd3) |=> lnk_clk);

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ibuf_cnt <= ($clog2(IBUF_DEPTH+1))'(IBUF_DEPTH));

    assert_refuse_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sts_ibuf_full) |=> (sts_ovf && sts_ibuf_cnt <= $past(sts_ibuf_cnt)));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ovf && !err_clr) |=> sts_ovf);

endmodule

bind lnk_tx_top lnk_tx_chk #(
    .LINK_W     (LINK_W),
    .IBUF_DEPTH (IBUF_DEPTH)
) i_lnk_tx_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_ratio     (cfg_ratio),
    .wr_en         (wr_en),
    .err_clr       (err_clr),
    .lnk_clk       (lnk_clk),
    .lnk_data      (lnk_data),
    .sts_ibuf_cnt  (sts_ibuf_cnt),
    .sts_ibuf_full (sts_ibuf_full),
    .sts_tx_active (sts_tx_active),
    .sts_ovf       (sts_ovf)
);

// File: tb/test_lnk_tx_top.sv
module test_lnk_tx_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2;
    localparam int CW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cfg_ratio;
    logic          wr_en;
    logic [31:0]   wr_data;
    logic          err_clr;
    logic          lnk_ack;
    logic          lnk_clk;
    logic [7:0]    lnk_data;
    logic [CW-1:0] sts_ibuf_cnt;
    logic          sts_ibuf_full;
    logic          sts_tx_active;
    logic          sts_ovf;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] exp_q[$];
    int          rx_words = 0;
    int          rises    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lnk_tx_top #(
        .WORD_W     (32),
        .LINK_W     (8),
        .IBUF_DEPTH (DEPTH)
    ) i_lnk_tx_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_ratio     (cfg_ratio),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .err_clr       (err_clr),
        .lnk_ack       (lnk_ack),
        .lnk_clk       (lnk_clk),
        .lnk_data      (lnk_data),
        .sts_ibuf_cnt  (sts_ibuf_cnt),
        .sts_ibuf_full (sts_ibuf_full),
        .sts_tx_active (sts_tx_active),
        .sts_ovf       (sts_ovf)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_period(input int r, input int k);
        case (r)
            0:       return 2;
            1:       return (k % 2 == 0) ? 2 : 3;
            2:       return 3;
            default: return 4;
        endcase
    endfunction

    function automatic logic [31:0] make_word(input int r, input int n, input int i);
        return {8'(16*r + n), 8'(i), 8'(8'hA5 ^ i), 8'(37*i + r)};
    endfunction

    // link receiver model: sampled mid-cycle
    logic        prev_clk = 1'b0;
    int          gap      = 0;
    int          hi_cnt   = 0;
    int          burst_k  = 0;
    int          byte_n   = 0;
    logic [31:0] rx_acc   = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            gap++;
            if (lnk_clk) hi_cnt++;
            if (lnk_clk && !prev_clk) begin
                rises++;
                if (burst_k > 0) begin
                    chk(gap == exp_period(int'(cfg_ratio), burst_k - 1), "R2/R5",
                        "link period", gap, exp_period(int'(cfg_ratio), burst_k - 1));
                end
                burst_k++;
                gap    = 0;
                rx_acc = rx_acc | (32'(lnk_data) << (8 * byte_n));
                byte_n++;
                if (byte_n == 4) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8", "unexpected word", rx_acc, 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        chk(rx_acc == e, "R4", "received word", rx_acc, e);
                    end
                    rx_words++;
                    byte_n = 0;
                    rx_acc = '0;
                end
            end
            if (!lnk_clk && prev_clk) begin
                chk(hi_cnt == ((cfg_ratio == 2'd3) ? 2 : 1), "R3", "high time",
                    hi_cnt, (cfg_ratio == 2'd3) ? 2 : 1);
                hi_cnt = 0;
            end
            if (!sts_tx_active) burst_k = 0;
            prev_clk = lnk_clk;
        end
    end

    task automatic write_word(input logic [31:0] w, input bit expect_tx);
        @(negedge clk);
        while (sts_ibuf_full) @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        if (expect_tx) exp_q.push_back(w);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_drain();
        do @(negedge clk); while (exp_q.size() != 0 || sts_tx_active);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n     = 1'b0;
        cfg_ratio = 2'd0;
        wr_en     = 1'b0;
        wr_data   = '0;
        err_clr   = 1'b0;
        lnk_ack   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(lnk_clk == 1'b0, "R1", "lnk_clk", lnk_clk, 0);
        chk(lnk_data == 8'h0, "R1", "lnk_data", lnk_data, 0);
        chk(sts_ibuf_cnt == '0, "R1", "occupancy", sts_ibuf_cnt, 0);
        chk(sts_tx_active == 1'b0, "R1", "active", sts_tx_active, 0);
        chk(sts_ovf == 1'b0, "R1", "ovf", sts_ovf, 0);

        // R10 start latency
        lnk_ack = 1'b1;
        write_word(32'h4433_2211, 1'b1);
        @(negedge clk);
        chk(sts_tx_active == 1'b1, "R10", "active after 1 cycle", sts_tx_active, 1);
        chk(lnk_clk == 1'b0, "R10", "clk after 1 cycle", lnk_clk, 0);
        @(negedge clk);
        chk(lnk_clk == 1'b1, "R10", "clk after 2 cycles", lnk_clk, 1);
        chk(lnk_data == 8'h11, "R10", "first byte", lnk_data, 8'h11);
        wait_drain();

        // R2 R4 R5 sweep: every ratio, burst lengths 1..5
        for (int r = 0; r < 4; r++) begin
            cfg_ratio = 2'(r);
            for (int n = 1; n <= 5; n++) begin
                int base;
                base = rx_words;
                for (int i = 0; i < n; i++) write_word(make_word(r, n, i), 1'b1);
                wait_drain();
                chk(rx_words - base == n, "R5", "words per burst", rx_words - base, n);
            end
        end

        // R6 acknowledge only at word boundaries
        cfg_ratio = 2'd2;
        begin
            int base;
            int r0;
            base = rx_words;
            write_word(32'hCAFE_0001, 1'b1);
            write_word(32'hCAFE_0002, 1'b1);
            while (!lnk_clk) @(negedge clk);
            lnk_ack = 1'b0;
            while (sts_tx_active) @(negedge clk);
            chk(rx_words - base == 1, "R6", "words before park", rx_words - base, 1);
            chk(sts_ibuf_cnt == CW'(1), "R6", "buffered word kept", sts_ibuf_cnt, 1);
            r0 = rises;
            repeat (20) @(negedge clk);
            chk(rises == r0, "R6", "no edges while parked", rises - r0, 0);
            chk(lnk_clk == 1'b0, "R6", "clk parked low", lnk_clk, 0);
            lnk_ack = 1'b1;
            wait_drain();
            chk(rx_words - base == 2, "R6", "resume after ack", rx_words - base, 2);
        end

        // R7 R8 R9 overflow handling
        lnk_ack = 1'b0;
        cfg_ratio = 2'd1;
        for (int i = 0; i < DEPTH; i++) write_word(32'h5A00_0000 + 32'(i), 1'b1);
        chk(sts_ibuf_cnt == CW'(DEPTH), "R7", "occupancy full", sts_ibuf_cnt, DEPTH);
        chk(sts_ibuf_full == 1'b1, "R7", "full flag", sts_ibuf_full, 1);
        chk(sts_ovf == 1'b0, "R8", "ovf before refusal", sts_ovf, 0);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        wr_en = 1'b0;
        chk(sts_ovf == 1'b1, "R8", "ovf set", sts_ovf, 1);
        chk(sts_ibuf_cnt == CW'(DEPTH), "R8", "occupancy unchanged", sts_ibuf_cnt, DEPTH);
        repeat (10) @(negedge clk);
        chk(sts_ovf == 1'b1, "R9", "ovf sticky", sts_ovf, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(sts_ovf == 1'b0, "R9", "ovf cleared", sts_ovf, 0);
        wr_en   = 1'b1;
        err_clr = 1'b1;
        wr_data = 32'hBAD0_BAD0;
        @(negedge clk);
        wr_en   = 1'b0;
        err_clr = 1'b0;
        chk(sts_ovf == 1'b1, "R9", "set beats clear", sts_ovf, 1);
        begin
            int base;
            base = rx_words;
            lnk_ack = 1'b1;
            wait_drain();
            repeat (10) @(negedge clk);
            chk(rx_words - base == DEPTH, "R8", "refused words not sent", rx_words - base, DEPTH);
            chk(sts_ibuf_cnt == '0, "R7", "drained", sts_ibuf_cnt, 0);
        end

        finish_run();
    end

endmodule